// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block keeps an asynchronous DRAM alive on behalf of its controller. An interval timer marks each moment at which one more refresh is owed. The block then asks the access sequencer for the bus, and once it is granted it runs a CAS#-before-RAS# (CBR) cycle. In such a cycle the device takes the row from its own internal counter, so the block drives no address. If the grant is held back, owed refreshes pile up to a parameterised limit. When the bus arrives they run back to back. An error flag latches if the limit is exceeded.

A sleep request turns the next CBR cycle into self-refresh. RAS# and CAS# stay low for as long as the request lasts, and never for less than the device minimum. The acknowledge rises once that minimum has passed. When the request is withdrawn, both strobes go high for the device recovery time. In distributed mode the bus is then handed back. Otherwise a burst of CBR cycles covering the whole array runs first. All timings are parameters counted in clock cycles.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is high and on the first cycle after it, ras_n, cas_n and we_n are 1, and bus_req, sleep_ack and owed_ovf are 0.
- R2: Outside a sleep sequence, one refresh becomes owed every REFRESH_INTERVAL cycles. Each owed refresh produces exactly one RAS# falling edge.
- R3: bus_req is 1 while any refresh or sleep work is outstanding and 0 once the block has returned to idle. ras_n or cas_n is 0 only while bus_req and bus_gnt are both 1.
- R4: In every refresh cycle cas_n falls T_CSR cycles before ras_n falls, and ras_n then stays low for exactly T_RAS cycles. we_n is 1 on every cycle.
- R5: Between two refresh cycles issued without releasing the bus, ras_n and cas_n are both high for exactly T_RP cycles.
- R6: Up to MAX_PEND owed refreshes are kept while the grant is withheld. After the grant they all run back to back without dropping bus_req.
- R7: A new refresh falling due while MAX_PEND are already owed sets owed_ovf. owed_ovf stays 1 until reset.
- R8: A sleep_req seen while idle starts a CBR cycle with cas_n falling before ras_n. Both strobes then stay low, and sleep_ack rises on the T_RASS-th cycle of ras_n low.
- R9: ras_n stays low for at least T_RASS cycles in self-refresh, even when sleep_req drops after a single cycle.
- R10: After sleep_req is 0 and T_RASS has elapsed, sleep_ack falls and both strobes stay high for exactly T_RPS cycles before anything else happens.
- R11: With dist_mode = 1, bus_req drops right after the T_RPS recovery and no refresh cycle follows it.
- R12: With dist_mode = 0, exactly BURST_ROWS CBR cycles follow the recovery, spaced T_RP apart, and then bus_req drops.
- R13: Throughout a sleep sequence the interval timer and the owed count are held at zero. A sleep of any length therefore raises no owed_ovf and no extra refresh. Timed refresh restarts after the sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dist_mode | input | 1 | 1: distributed refresh in use, no burst after self-refresh |
| sleep_req | input | 1 | Level request to enter and stay in self-refresh |
| sleep_ack | output | 1 | Self-refresh established (minimum hold met) |
| bus_req | output | 1 | Request for the DRAM bus |
| bus_gnt | input | 1 | Bus granted by the access sequencer |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| owed_ovf | output | 1 | Sticky overflow of the owed-refresh count |

## Verification
The assertions check, on every cycle, the rules that hold whatever the traffic. CAS# must already be low when RAS# falls. The strobes stay inside the granted window. Each RAS# low period lasts at least T_RAS cycles, and each CAS# falling edge is preceded by at least T_RP cycles of precharge. The owed count stays in range, the overflow flag is sticky, and the acknowledge coincides with both strobes low and an empty owed count. Only the scenarios can show the quantities that depend on history: how many refreshes a window produces, draining after a late grant, the exact recovery length, and the burst count that depends on dist_mode.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_CAS,
        ST_RAS,
        ST_PRE,
        ST_SELF,
        ST_WAKE
    } rfsh_state_e;

    typedef struct packed {
        logic ras_on;
        logic cas_on;
    } strobe_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobe_of(input rfsh_state_e st);
        strobe_t s;
        s.ras_on = (st == ST_RAS) || (st == ST_SELF);
        s.cas_on = (st == ST_CAS) || (st == ST_RAS) || (st == ST_SELF);
        return s;
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
    parameter int unsigned INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic tick
);
    localparam int unsigned TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [TW-1:0] cnt;

    assign tick = !hold && (cnt == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_owed.sv
module rfsh_owed #(
    parameter int unsigned MAX_PEND = 8,
    parameter int unsigned CW       = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic          done,
    output logic          owed_nz,
    output logic [CW-1:0] owed_cnt,
    output logic          ovf
);
    assign owed_nz = (owed_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            owed_cnt <= '0;
            ovf      <= 1'b0;
        end else if (clr) begin
            owed_cnt <= '0;
        end else begin
            case ({tick, done})
                2'b10: begin
                    if (owed_cnt == CW'(MAX_PEND)) begin
                        ovf <= 1'b1;
                    end else begin
                        owed_cnt <= owed_cnt + 1'b1;
                    end
                end
                2'b01: begin
                    if (owed_nz) begin
                        owed_cnt <= owed_cnt - 1'b1;
                    end
                end
                default: begin
                    owed_cnt <= owed_cnt;
                end
            endcase
        end
    end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int unsigned T_CSR      = 1,
    parameter int unsigned T_RAS      = 6,
    parameter int unsigned T_RP       = 4,
    parameter int unsigned T_RASS     = 10000,
    parameter int unsigned T_RPS      = 11,
    parameter int unsigned BURST_ROWS = 4096
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    owed_nz,
    input  logic    sleep_req,
    input  logic    bus_gnt,
    input  logic    dist_mode,
    output logic    bus_req,
    output logic    sleep_ack,
    output logic    sleep_seq,
    output logic    done,
    output strobe_t strobe
);
    localparam int unsigned DMAX = umax(umax(umax(T_CSR, T_RAS), umax(T_RP, T_RASS)), T_RPS);
    localparam int unsigned DW   = $clog2(DMAX + 1);
    localparam int unsigned BW   = $clog2(BURST_ROWS + 1);

    rfsh_state_e   state, state_n;
    logic [DW-1:0] dcnt, dcnt_n;
    logic [BW-1:0] left, left_n;
    logic          sleep_n;
    logic          in_burst, burst_n;
    logic          dzero;

    assign dzero = (dcnt == '0);

    always_comb begin
        state_n = state;
        dcnt_n  = dzero ? dcnt : dcnt - 1'b1;
        left_n  = left;
        sleep_n = sleep_seq;
        burst_n = in_burst;
        done    = 1'b0;
        case (state)
            ST_IDLE: begin
                sleep_n = 1'b0;
                burst_n = 1'b0;
                if (sleep_req) begin
                    state_n = ST_REQ;
                    sleep_n = 1'b1;
                end else if (owed_nz) begin
                    state_n = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    state_n = ST_CAS;
                    dcnt_n  = DW'(T_CSR - 1);
                end
            end
            ST_CAS: begin
                if (dzero) begin
                    if (sleep_seq && !in_burst) begin
                        state_n = ST_SELF;
                        dcnt_n  = DW'(T_RASS - 1);
                    end else begin
                        state_n = ST_RAS;
                        dcnt_n  = DW'(T_RAS - 1);
                    end
                end
            end
            ST_RAS: begin
                if (dzero) begin
                    state_n = ST_PRE;
                    dcnt_n  = DW'(T_RP - 1);
                    done    = !sleep_seq;
                end
            end
            ST_PRE: begin
                if (dzero) begin
                    if (in_burst) begin
                        if (left != '0) begin
                            left_n  = left - 1'b1;
                            state_n = ST_CAS;
                            dcnt_n  = DW'(T_CSR - 1);
                        end else begin
                            state_n = ST_IDLE;
                            sleep_n = 1'b0;
                            burst_n = 1'b0;
                        end
                    end else if (owed_nz) begin
                        state_n = ST_CAS;
                        dcnt_n  = DW'(T_CSR - 1);
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_SELF: begin
                if (dzero && !sleep_req) begin
                    state_n = ST_WAKE;
                    dcnt_n  = DW'(T_RPS - 1);
                end
            end
            ST_WAKE: begin
                if (dzero) begin
                    if (dist_mode) begin
                        state_n = ST_IDLE;
                        sleep_n = 1'b0;
                    end else begin
                        burst_n = 1'b1;
                        left_n  = BW'(BURST_ROWS - 1);
                        state_n = ST_CAS;
                        dcnt_n  = DW'(T_CSR - 1);
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            dcnt      <= '0;
            left      <= '0;
            sleep_seq <= 1'b0;
            in_burst  <= 1'b0;
        end else begin
            state     <= state_n;
            dcnt      <= dcnt_n;
            left      <= left_n;
            sleep_seq <= sleep_n;
            in_burst  <= burst_n;
        end
    end

    assign bus_req   = (state != ST_IDLE);
    assign sleep_ack = (state == ST_SELF) && dzero;
    assign strobe    = strobe_of(state);
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int unsigned REFRESH_INTERVAL = 1560,
    parameter int unsigned T_CSR            = 1,
    parameter int unsigned T_RAS            = 6,
    parameter int unsigned T_RP             = 4,
    parameter int unsigned T_RASS           = 10000,
    parameter int unsigned T_RPS            = 11,
    parameter int unsigned BURST_ROWS       = 4096,
    parameter int unsigned MAX_PEND         = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic dist_mode,
    input  logic sleep_req,
    output logic sleep_ack,
    output logic bus_req,
    input  logic bus_gnt,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic owed_ovf
);
    localparam int unsigned CW = $clog2(MAX_PEND + 1);

    logic          tick;
    logic          done;
    logic          owed_nz;
    logic          sleep_seq;
    logic [CW-1:0] owed_cnt;
    strobe_t       strobe;

    rfsh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .hold (sleep_seq),
        .tick (tick)
    );

    rfsh_owed #(.MAX_PEND(MAX_PEND), .CW(CW)) u_owed (
        .clk      (clk),
        .rst      (rst),
        .clr      (sleep_seq),
        .tick     (tick),
        .done     (done),
        .owed_nz  (owed_nz),
        .owed_cnt (owed_cnt),
        .ovf      (owed_ovf)
    );

    rfsh_seq #(
        .T_CSR      (T_CSR),
        .T_RAS      (T_RAS),
        .T_RP       (T_RP),
        .T_RASS     (T_RASS),
        .T_RPS      (T_RPS),
        .BURST_ROWS (BURST_ROWS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .owed_nz   (owed_nz),
        .sleep_req (sleep_req),
        .bus_gnt   (bus_gnt),
        .dist_mode (dist_mode),
        .bus_req   (bus_req),
        .sleep_ack (sleep_ack),
        .sleep_seq (sleep_seq),
        .done      (done),
        .strobe    (strobe)
    );

    assign ras_n = !(strobe.ras_on && bus_gnt);
    assign cas_n = !(strobe.cas_on && bus_gnt);
    assign we_n  = 1'b1;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk
    import rfsh_pkg::*;
#(
    parameter int unsigned T_RAS    = 6,
    parameter int unsigned T_RP     = 4,
    parameter int unsigned T_RASS   = 10000,
    parameter int unsigned MAX_PEND = 8,
    parameter int unsigned CW       = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          ras_n,
    input logic          cas_n,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          sleep_ack,
    input logic          owed_ovf,
    input logic [CW-1:0] owed_cnt
);
    localparam int unsigned LCAP = umax(T_RASS, T_RAS) + 1;
    localparam int unsigned LW   = $clog2(LCAP + 1);
    localparam int unsigned HW   = $clog2(T_RP + 1);

    logic [LW-1:0] low_run;
    logic [HW-1:0] high_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            high_run <= HW'(T_RP);
        end else begin
            if (!ras_n) begin
                if (low_run != LW'(LCAP)) low_run <= low_run + 1'b1;
            end else begin
                low_run <= '0;
            end
            if (!ras_n) begin
                high_run <= '0;
            end else if (cas_n && high_run != HW'(T_RP)) begin
                high_run <= high_run + 1'b1;
            end
        end
    end

    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $past(!cas_n)); // R4
    AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (rst)
        (!ras_n || !cas_n) |-> (bus_req && bus_gnt)); // R3
    AST_RAS_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (low_run >= LW'(T_RAS))); // R4
    AST_PRECHARGE_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> (high_run >= HW'(T_RP))); // R5
    AST_ACK_STROBES_LOW: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> (!ras_n && !cas_n)); // R8
    AST_ACK_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_ack) |-> (low_run >= LW'(T_RASS - 1))); // R9
    AST_OWED_RANGE: assert property (@(posedge clk) disable iff (rst)
        owed_cnt <= CW'(MAX_PEND)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(owed_ovf) |-> owed_ovf); // R7
    AST_SLEEP_NO_OWED: assert property (@(posedge clk) disable iff (rst)
        sleep_ack |-> (owed_cnt == '0)); // R13
endmodule

bind rfsh_sched rfsh_sched_chk #(
    .T_RAS    (T_RAS),
    .T_RP     (T_RP),
    .T_RASS   (T_RASS),
    .MAX_PEND (MAX_PEND),
    .CW       (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .sleep_ack (sleep_ack),
    .owed_ovf  (owed_ovf),
    .owed_cnt  (owed_cnt)
);

// File: tb/sim_rfsh_sched.sv
module sim_rfsh_sched;
    localparam int CLK_PERIOD = 10;
    localparam int P_INT   = 40;
    localparam int P_CSR   = 2;
    localparam int P_RAS   = 4;
    localparam int P_RP    = 3;
    localparam int P_RASS  = 20;
    localparam int P_RPS   = 6;
    localparam int P_BURST = 4;
    localparam int P_PEND  = 3;

    typedef struct packed {
        int   delay;
        int   win;
        int   falls;
        logic req_end;
        logic ovf;
    } row_t;

    localparam row_t ROWS [4] = '{
        '{delay: 0,   win: 190, falls: 4, req_end: 1'b0, ovf: 1'b0},
        '{delay: 5,   win: 190, falls: 4, req_end: 1'b0, ovf: 1'b0},
        '{delay: 80,  win: 200, falls: 3, req_end: 1'b1, ovf: 1'b0},
        '{delay: 200, win: 185, falls: 0, req_end: 1'b1, ovf: 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dist_mode = 1'b1;
    logic sleep_req = 1'b0;
    logic bus_gnt = 1'b0;
    logic sleep_ack, bus_req, ras_n, cas_n, we_n, owed_ovf;

    int checks = 0;
    int errors = 0;
    int gnt_delay = 0;
    int wait_cnt = 0;

    int ras_falls = 0;
    int idx = 0;
    int leads [16];
    int widths [16];
    int gaps [16];
    int cas_run = 0;
    int ras_run = 0;
    int hi_run = 0;
    int viol = 0;
    int we_low = 0;
    logic prev_ras = 1'b1;

    rfsh_sched #(
        .REFRESH_INTERVAL (P_INT),
        .T_CSR            (P_CSR),
        .T_RAS            (P_RAS),
        .T_RP             (P_RP),
        .T_RASS           (P_RASS),
        .T_RPS            (P_RPS),
        .BURST_ROWS       (P_BURST),
        .MAX_PEND         (P_PEND)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .dist_mode (dist_mode),
        .sleep_req (sleep_req),
        .sleep_ack (sleep_ack),
        .bus_req   (bus_req),
        .bus_gnt   (bus_gnt),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .owed_ovf  (owed_ovf)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Arbiter model: grant after gnt_delay cycles of request, drop with request.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_req) begin
                if (wait_cnt >= gnt_delay) bus_gnt = 1'b1;
                else wait_cnt++;
            end else begin
                bus_gnt  = 1'b0;
                wait_cnt = 0;
            end
        end
    end

    // Strobe monitor, sampled after the grant driver.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                prev_ras = 1'b1;
                cas_run  = 0;
                ras_run  = 0;
                hi_run   = 0;
            end else begin
                if (!we_n) we_low++;
                if ((!ras_n || !cas_n) && !(bus_req && bus_gnt)) viol++;
                if (prev_ras && !ras_n) begin
                    if (idx < 16) begin
                        leads[idx] = cas_run;
                        gaps[idx]  = hi_run;
                    end
                    idx++;
                    ras_falls++;
                    ras_run = 1;
                    cas_run = 0;
                end else if (!ras_n) begin
                    ras_run++;
                end else if (!prev_ras && ras_n) begin
                    if (idx > 0 && idx <= 16) widths[idx-1] = ras_run;
                    hi_run = 0;
                end
                if (ras_n) begin
                    if (cas_n) hi_run++;
                    else cas_run++;
                end
                prev_ras = ras_n;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lo);
        checks++;
        if (act < lo) begin
            errors++;
            $display("FAIL %s: actual %0d expected >= %0d", req, act, lo);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sleep_req = 1'b0;
        repeat (3) step();
        ras_falls = 0;
        idx = 0;
        rst = 1'b0;
    endtask

    task automatic check_idle_outputs(input string req);
        chk_eq(req, int'(ras_n), 1);
        chk_eq(req, int'(cas_n), 1);
        chk_eq(req, int'(we_n), 1);
        chk_eq(req, int'(bus_req), 0);
        chk_eq(req, int'(sleep_ack), 0);
        chk_eq(req, int'(owed_ovf), 0);
    endtask

    initial begin
        int n;
        // R1: reset state
        rst = 1'b1;
        repeat (3) step();
        check_idle_outputs("R1 in reset");
        rst = 1'b0;
        step();
        check_idle_outputs("R1 after reset");

        // Table walk: R2 timed refresh, R6 postponement, R7 overflow
        for (int r = 0; r < 4; r++) begin
            gnt_delay = ROWS[r].delay;
            dist_mode = 1'b1;
            do_reset();
            repeat (ROWS[r].win) step();
            chk_eq("R2 refresh count", ras_falls, ROWS[r].falls);
            chk_eq("R3 bus_req at window end", int'(bus_req), int'(ROWS[r].req_end));
            chk_eq("R7 overflow flag", int'(owed_ovf), int'(ROWS[r].ovf));
            for (int i = 0; i < ROWS[r].falls; i++) begin
                chk_eq("R4 cas lead", leads[i], P_CSR);
                chk_eq("R4 ras width", widths[i], P_RAS);
            end
            if (r == 2) begin
                chk_eq("R6 back-to-back gap 1", gaps[1], P_RP);
                chk_eq("R5 back-to-back gap 2", gaps[2], P_RP);
            end
        end

        // R7: overflow stays set after the queue drains
        repeat (100) step();
        chk_eq("R7 sticky", int'(owed_ovf), 1);
        gnt_delay = 0;
        do_reset();
        chk_eq("R1 overflow cleared", int'(owed_ovf), 0);

        // R8, R10, R11: sleep with distributed mode
        dist_mode = 1'b1;
        repeat (5) step();
        idx = 0;
        sleep_req = 1'b1;
        n = 0;
        while (!sleep_ack && n < 100) begin step(); n++; end
        chk_eq("R8 ack seen", int'(sleep_ack), 1);
        chk_eq("R8 ras low at ack", ras_run, P_RASS);
        chk_eq("R8 cas leads ras", leads[0], P_CSR);
        repeat (30) step();
        sleep_req = 1'b0;
        n = 0;
        while (sleep_ack && n < 100) begin step(); n++; end
        chk_eq("R10 ras high after ack falls", int'(ras_n), 1);
        n = 0;
        while (bus_req && n < 100) begin n++; step(); end
        chk_eq("R10 recovery length", n, P_RPS);
        repeat (20) step();
        chk_eq("R11 no burst", idx, 1);
        chk_eq("R11 bus released", int'(bus_req), 0);
        chk_ge("R9 self-refresh width", widths[0], P_RASS);

        // R9, R12: one-cycle sleep pulse, burst mode
        do_reset();
        dist_mode = 1'b0;
        step();
        idx = 0;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        n = 0;
        while (!(idx >= 1 + P_BURST && !bus_req) && n < 400) begin step(); n++; end
        chk_eq("R9 minimum hold", widths[0], P_RASS);
        chk_eq("R10 gap before burst", gaps[1], P_RPS);
        chk_eq("R12 burst count", idx, 1 + P_BURST);
        for (int i = 1; i <= P_BURST; i++) begin
            chk_eq("R12 burst width", widths[i], P_RAS);
            chk_eq("R12 burst lead", leads[i], P_CSR);
            if (i > 1) chk_eq("R12 burst spacing", gaps[i], P_RP);
        end
        repeat (20) step();
        chk_eq("R12 bus released", int'(bus_req), 0);

        // R13: long sleep, then timed refresh resumes
        do_reset();
        dist_mode = 1'b1;
        step();
        idx = 0;
        sleep_req = 1'b1;
        repeat (300) step();
        chk_eq("R13 no overflow in sleep", int'(owed_ovf), 0);
        chk_eq("R13 no extra refresh", idx, 1);
        chk_eq("R8 still acknowledged", int'(sleep_ack), 1);
        sleep_req = 1'b0;
        repeat (60) step();
        chk_eq("R13 timed refresh resumes", idx, 2);

        chk_eq("R3 strobes only when granted", viol, 0);
        chk_eq("R4 we_n high", we_low, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule